// File: doc/BRIEF.md
# Zone Temperature Fan Duty Controller

This block turns one 8-bit zone temperature into a target fan duty for a downstream ramp limiter and PWM generator. Above a programmable start temperature the duty climbs in a straight line from a programmed floor duty to full scale (FFh) across a programmable span of degrees. At the top of the span, and whenever the zone reaches an absolute ceiling, the duty is full scale. Below the start temperature a mode bit picks between stopping the fan and holding it at the floor duty. A running fan stops only once the temperature falls a programmable hysteresis below the start point. Each start from standstill is preceded by a full-duty kick of programmable length, which a "fan is turning" indication can end early.

Control lives in a six-state machine. FZ_IDLE holds while monitoring is not running and drives full duty. FZ_OFF drives zero. FZ_SPIN drives full duty during the kick. FZ_ON drives the curve value. FZ_MANUAL passes the software duty through. FZ_DISABLED drives zero.

Transitions are checked in priority order. From any state, `run` low goes to FZ_IDLE. Otherwise `fan_disable` goes to FZ_DISABLED. Otherwise `manual_en` goes to FZ_MANUAL. In automatic operation the transitions are:
- FZ_IDLE and FZ_MANUAL go to FZ_ON when the fan should run, and to FZ_OFF otherwise.
- FZ_OFF and FZ_DISABLED go to FZ_SPIN when the fan should run.
- FZ_SPIN goes to FZ_ON when the kick time expires, or on an early exit.
- FZ_ON goes to FZ_OFF when the fan should stop.

Outputs are registered from the next state, so they respond one clock after the inputs change.

Top module: `fan_zone_duty`

## Requirements
- R1: Out of reset, and on the clock after any cycle with `run` low, `duty` is FFh and `spin_active` is 0.
- R2: In automatic operation with the fan running and start <= T < start+span (span > 0), `duty` = floor + ((FFh - floor) * (T - start)) / span, using integer division. This value is never below the floor duty.
- R3: When T >= start+span (a 9-bit sum, so it can exceed 255), `duty` is FFh.
- R4: With `off_below` = 0 and T below the start temperature, `duty` is the floor duty and the fan never stops.
- R5: With `off_below` = 1, a stopped fan stays at duty 0 while T is below the start temperature. A running fan holds the floor duty while T >= start - hysteresis (saturating at 0), and drops to duty 0 once T falls below that.
- R6: A start from FZ_OFF or FZ_DISABLED drives `duty` = FFh with `spin_active` = 1 for exactly max(`spin_cycles`, 1) clocks. After that, the curve value follows.
- R7: With `spin_reduce_en` = 1, a cycle with `tach_ok` = 1 during the kick ends it, and the next output is the curve value. With `spin_reduce_en` = 0, `tach_ok` has no effect.
- R8: In automatic operation, T >= `abs_limit` forces `duty` to FFh on the next clock. This holds even from the stopped state, which then starts a kick.
- R9: With `manual_en` = 1 (and `fan_disable` = 0), `duty` equals `manual_duty` on the next clock and `spin_active` is 0, whatever the temperature.
- R10: With `fan_disable` = 1, `duty` is 0. When the disable is released and the fan should run, a kick begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Monitoring active; low forces full duty |
| manual_en | input | 1 | Pass software duty through |
| manual_duty | input | 8 | Software duty |
| fan_disable | input | 1 | Force duty 0 |
| off_below | input | 1 | 1: stop below start temperature; 0: hold floor duty |
| zone_temp | input | 8 | Zone temperature |
| t_start | input | 8 | Start temperature of the curve |
| t_span | input | 8 | Curve span in degrees |
| floor_duty | input | 8 | Floor duty |
| abs_limit | input | 8 | Absolute ceiling temperature |
| hyst | input | 8 | Stop hysteresis in degrees |
| spin_cycles | input | 16 | Kick length in clocks |
| spin_reduce_en | input | 1 | Allow early end of the kick |
| tach_ok | input | 1 | Fan speed indication above its limit |
| duty | output | 8 | Target duty |
| spin_active | output | 1 | Kick in progress |

## Verification
A wrong state register shows at the ports on the very next clock. Examples are a duty of 0 where FFh belongs, a spin flag high outside a kick, or a fan that stops inside the hysteresis band. A wrong kick counter shows as a kick that is one or more clocks too long or too short, and this is counted exactly. An arithmetic slip in the curve shows as an off-by-some duty at particular temperatures. For this reason the curve is swept over every temperature from 0 to 127 under several span and floor settings.

// File: rtl/fan_zone_pkg.sv
package fan_zone_pkg;
    typedef enum logic [2:0] {
        FZ_IDLE     = 3'd0,
        FZ_OFF      = 3'd1,
        FZ_SPIN     = 3'd2,
        FZ_ON       = 3'd3,
        FZ_MANUAL   = 3'd4,
        FZ_DISABLED = 3'd5
    } fz_state_e;
endpackage

// File: rtl/fzd_curve.sv
module fzd_curve #(
    parameter int TW = 8,
    parameter int DW = 8
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] t_start,
    input  logic [TW-1:0] t_span,
    input  logic [DW-1:0] floor_duty,
    input  logic [TW-1:0] abs_limit,
    input  logic [TW-1:0] hyst,
    input  logic          off_below,
    input  logic          fan_on,
    output logic          want_on,
    output logic [DW-1:0] duty_on
);
    localparam int PW = DW + TW;
    localparam logic [DW-1:0] FULL = {DW{1'b1}};

    logic          abs_hit;
    logic [TW:0]   top_t;
    logic [TW-1:0] stop_t;
    logic [TW-1:0] delta;
    logic [DW-1:0] span_d;
    logic [TW-1:0] divisor;
    logic [PW-1:0] prod;
    logic [PW-1:0] quot;
    logic [PW:0]   sum;

    always_comb begin
        abs_hit = (temp >= abs_limit);
        top_t   = {1'b0, t_start} + {1'b0, t_span};
        stop_t  = (t_start > hyst) ? (t_start - hyst) : '0;
        want_on = abs_hit || !off_below || (temp >= t_start)
                  || (fan_on && (temp >= stop_t));

        delta   = temp - t_start;
        span_d  = FULL - floor_duty;
        divisor = (t_span == '0) ? {{(TW-1){1'b0}}, 1'b1} : t_span;
        prod    = {{TW{1'b0}}, span_d} * {{DW{1'b0}}, delta};
        quot    = prod / {{DW{1'b0}}, divisor};
        sum     = {1'b0, quot} + {{(TW+1){1'b0}}, floor_duty};

        if (abs_hit || ({1'b0, temp} >= top_t))
            duty_on = FULL;
        else if (temp >= t_start)
            duty_on = (sum > {{(TW+1){1'b0}}, FULL}) ? FULL : sum[DW-1:0];
        else
            duty_on = floor_duty;
    end
endmodule

// File: rtl/fzd_spin_timer.sv
module fzd_spin_timer #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [SW-1:0] limit,
    input  logic          early,
    output logic          done
);
    logic [SW-1:0] cnt;

    assign done = early || (({1'b0, cnt} + 1'b1) >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (active) cnt <= cnt + 1'b1;
        else             cnt <= '0;
    end

    // R6: while kicking, the count never reaches the programmed length
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((cnt < limit) || (cnt == '0)));
endmodule

// File: rtl/fan_zone_duty.sv
module fan_zone_duty
    import fan_zone_pkg::*;
#(
    parameter int TW = 8,
    parameter int DW = 8,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          manual_en,
    input  logic [DW-1:0] manual_duty,
    input  logic          fan_disable,
    input  logic          off_below,
    input  logic [TW-1:0] zone_temp,
    input  logic [TW-1:0] t_start,
    input  logic [TW-1:0] t_span,
    input  logic [DW-1:0] floor_duty,
    input  logic [TW-1:0] abs_limit,
    input  logic [TW-1:0] hyst,
    input  logic [SW-1:0] spin_cycles,
    input  logic          spin_reduce_en,
    input  logic          tach_ok,
    output logic [DW-1:0] duty,
    output logic          spin_active
);
    localparam logic [DW-1:0] FULL = {DW{1'b1}};

    fz_state_e     state_q, state_n;
    logic          want_on, fan_on, spin_done;
    logic [DW-1:0] curve_duty;

    assign fan_on = (state_q == FZ_ON) || (state_q == FZ_SPIN);

    fzd_curve #(.TW(TW), .DW(DW)) u_curve (
        .temp(zone_temp), .t_start(t_start), .t_span(t_span),
        .floor_duty(floor_duty), .abs_limit(abs_limit), .hyst(hyst),
        .off_below(off_below), .fan_on(fan_on),
        .want_on(want_on), .duty_on(curve_duty)
    );

    fzd_spin_timer #(.SW(SW)) u_spin (
        .clk(clk), .rst_n(rst_n), .active(state_q == FZ_SPIN),
        .limit(spin_cycles), .early(spin_reduce_en && tach_ok),
        .done(spin_done)
    );

    always_comb begin
        state_n = state_q;
        if (!run)
            state_n = FZ_IDLE;
        else if (fan_disable)
            state_n = FZ_DISABLED;
        else if (manual_en)
            state_n = FZ_MANUAL;
        else begin
            unique case (state_q)
                FZ_IDLE, FZ_MANUAL: state_n = want_on ? FZ_ON : FZ_OFF;
                FZ_OFF, FZ_DISABLED: state_n = want_on ? FZ_SPIN : FZ_OFF;
                FZ_SPIN:            state_n = spin_done ? FZ_ON : FZ_SPIN;
                FZ_ON:              state_n = want_on ? FZ_ON : FZ_OFF;
                default:            state_n = FZ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FZ_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty        <= FULL;
            spin_active <= 1'b0;
        end else begin
            spin_active <= (state_n == FZ_SPIN);
            unique case (state_n)
                FZ_IDLE, FZ_SPIN:    duty <= FULL;
                FZ_OFF, FZ_DISABLED: duty <= '0;
                FZ_MANUAL:           duty <= manual_duty;
                FZ_ON:               duty <= curve_duty;
                default:             duty <= FULL;
            endcase
        end
    end

    a_r1_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (duty == FULL) && !spin_active);
    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FZ_ON) |-> (duty >= $past(floor_duty)));
    a_r6_spin_full: assert property (@(posedge clk) disable iff (!rst_n)
        spin_active |-> (duty == FULL));
    a_r8_abs_full: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fan_disable && !manual_en && (zone_temp >= abs_limit))
        |=> (duty == FULL));
    a_r9_manual_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fan_disable && manual_en)
        |=> (duty == $past(manual_duty)) && !spin_active);
    a_r10_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fan_disable) |=> (duty == '0) && !spin_active);
endmodule

// File: tb/fan_zone_duty_test.sv
module fan_zone_duty_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, manual_en = 1'b0, fan_disable = 1'b0, off_below = 1'b0;
    logic [7:0]  manual_duty = '0, zone_temp = '0, t_start = 8'd40, t_span = 8'd16;
    logic [7:0]  floor_duty = 8'd64, abs_limit = 8'd250, hyst = '0;
    logic [15:0] spin_cycles = 16'd5;
    logic        spin_reduce_en = 1'b0, tach_ok = 1'b0;
    logic [7:0]  duty;
    logic        spin_active;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fan_zone_duty uut (
        .clk(clk), .rst_n(rst_n), .run(run), .manual_en(manual_en),
        .manual_duty(manual_duty), .fan_disable(fan_disable), .off_below(off_below),
        .zone_temp(zone_temp), .t_start(t_start), .t_span(t_span),
        .floor_duty(floor_duty), .abs_limit(abs_limit), .hyst(hyst),
        .spin_cycles(spin_cycles), .spin_reduce_en(spin_reduce_en),
        .tach_ok(tach_ok), .duty(duty), .spin_active(spin_active)
    );

    function automatic int curve_exp(int t, int ts, int sp, int fl, int ab);
        if (t >= ab) return 255;
        if (t >= ts + sp) return 255;
        if (t >= ts) return fl + ((255 - fl) * (t - ts)) / sp;
        return fl;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        int spans[3] = '{1, 16, 100};
        int floors[3] = '{0, 64, 200};
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset duty", duty, 255);
        chk("R1 reset spin", spin_active, 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle duty", duty, 255);

        // curve sweep: R2, R3, R4
        run = 1'b1;
        for (int si = 0; si < 3; si++) begin
            for (int fi = 0; fi < 3; fi++) begin
                t_span = 8'(spans[si]);
                floor_duty = 8'(floors[fi]);
                for (int t = 0; t < 128; t++) begin
                    zone_temp = 8'(t);
                    step();
                    if (t < 40)
                        chk("R4 below start", duty, floors[fi]);
                    else if (t >= 40 + spans[si])
                        chk("R3 above span", duty, 255);
                    else
                        chk("R2 linear", duty, curve_exp(t, 40, spans[si], floors[fi], 250));
                end
            end
        end

        // R5 stop, R6 kick with tach ignored (R7)
        t_span = 8'd16; floor_duty = 8'd64; hyst = 8'd5; off_below = 1'b1;
        spin_cycles = 16'd5; tach_ok = 1'b1; spin_reduce_en = 1'b0;
        zone_temp = 8'd10;
        step();
        chk("R5 stop", duty, 0);
        step();
        chk("R5 stay off", duty, 0);
        zone_temp = 8'd45;
        n = 0;
        step();
        while (spin_active && n < 100) begin
            chk("R6 kick full", duty, 255);
            n++;
            step();
        end
        chk("R6 R7 kick length", n, 5);
        chk("R6 after kick", duty, curve_exp(45, 40, 16, 64, 250));

        // R5 hysteresis band
        zone_temp = 8'd36; step();
        chk("R5 hold 36", duty, 64);
        zone_temp = 8'd35; step();
        chk("R5 hold 35", duty, 64);
        zone_temp = 8'd34; step();
        chk("R5 drop 34", duty, 0);
        zone_temp = 8'd39; step();
        chk("R5 no restart 39", duty, 0);
        chk("R5 no kick 39", spin_active, 0);

        // R6 zero length kick
        spin_cycles = 16'd0; zone_temp = 8'd40; step();
        chk("R6 min kick on", spin_active, 1);
        step();
        chk("R6 min kick off", spin_active, 0);
        chk("R6 min kick duty", duty, 64);

        // R7 early exit
        zone_temp = 8'd10; step();
        chk("R5 off again", duty, 0);
        spin_cycles = 16'd1000; spin_reduce_en = 1'b1; tach_ok = 1'b0;
        zone_temp = 8'd50;
        step();
        for (int k = 0; k < 3; k++) begin
            chk("R7 kick holds", spin_active, 1);
            step();
        end
        tach_ok = 1'b1;
        step();
        chk("R7 early end", spin_active, 0);
        chk("R7 early duty", duty, curve_exp(50, 40, 16, 64, 250));

        // R8 absolute ceiling
        t_span = 8'd100; abs_limit = 8'd60; zone_temp = 8'd59; step();
        chk("R8 below ceiling", duty, curve_exp(59, 40, 100, 64, 60));
        zone_temp = 8'd60; step();
        chk("R8 at ceiling", duty, 255);
        abs_limit = 8'd250; zone_temp = 8'd10; step();
        chk("R8 prep off", duty, 0);
        abs_limit = 8'd20; zone_temp = 8'd25; step();
        chk("R8 from off", duty, 255);
        chk("R8 kick", spin_active, 1);
        step();
        chk("R8 on ceiling", duty, 255);

        // R9 manual
        abs_limit = 8'd250; manual_en = 1'b1; manual_duty = 8'h33; zone_temp = 8'd200;
        step();
        chk("R9 manual duty", duty, 8'h33);
        chk("R9 manual no kick", spin_active, 0);
        manual_duty = 8'h00; step();
        chk("R9 manual zero", duty, 0);
        manual_en = 1'b0; zone_temp = 8'd10; step();
        chk("R9 leave to off", duty, 0);

        // R10 disable
        fan_disable = 1'b1; zone_temp = 8'd200; step();
        chk("R10 disabled", duty, 0);
        zone_temp = 8'd45; step();
        chk("R10 still disabled", duty, 0);
        spin_cycles = 16'd3; spin_reduce_en = 1'b0; fan_disable = 1'b0; step();
        chk("R10 release kick", spin_active, 1);
        chk("R10 release duty", duty, 255);

        run = 1'b0; step();
        chk("R1 run low duty", duty, 255);
        chk("R1 run low spin", spin_active, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule